// File: doc/BRIEF.md
# Rename Table with Branch Checkpoints

This block holds the map from architectural register numbers to physical tags for an out-of-order core. Each map entry carries either a physical tag or a flag saying that the committed register file already holds the newest value. The rename stage reads two source mappings and may install one new destination mapping per cycle. The commit stage sends a clear that sets an entry back to "value is in the committed register file" once the instruction that produced that tag retires.

Whenever a branch is renamed, the block takes a slot from a small pool of checkpoint slots and stores a complete copy of the map in it. If the branch resolves as correctly predicted, the slot goes back to the pool and the live map is left alone. If the branch was mispredicted, the live map is reloaded from that slot in a single cycle. In the same cycle the slot and every slot taken by a later branch are released, so renaming can resume on the next cycle without waiting for the pipeline to drain. When every slot is in use, a stall output tells the rename stage that it cannot rename another branch.

Top module: `rename_ckpt_table`

## Requirements
- R1: After reset, every map entry reads as held in the committed register file (inArf = 1, tag 0). No checkpoint slot is held, `brStall` is low and `brAllocId` is 0.
- R2: `srcAInArf/srcATag` and `srcBInArf/srcBTag` show the live map entries of `renSrcA` and `renSrcB` combinationally. They reflect the map as it stands before the same cycle's destination write.
- R3: When `renValid` and `renDstValid` are high and no mispredict is taken, the entry `renDstArch` becomes inArf = 0 with tag `renDstTag` from the next cycle.
- R4: `brAllocId` shows the lowest-numbered free slot. When `brAlloc` is high with a free slot and no mispredict is taken, that slot becomes held. It stores the map as it stands after the same cycle's destination write and commit clear.
- R5: `brStall` is high exactly when all checkpoint slots are held. A `brAlloc` request while `brStall` is high is ignored.
- R6: A resolve with `resMispredict` = 0 for a held slot returns that slot to the pool and leaves the live map unchanged.
- R7: A resolve with `resMispredict` = 1 for a held slot reloads the live map from that slot's copy on the next cycle. A destination write or branch allocation presented in that cycle is ignored.
- R8: A mispredict releases the mispredicted slot and every held slot that was allocated after it. Slots allocated before it stay held.
- R9: A commit clear (`cmtValid`, `cmtArch`, `cmtTag`) sets inArf = 1 for that register in the live map and in every stored copy, wherever that entry has inArf = 0 and tag equal to `cmtTag`.
- R10: A resolve naming a slot that is not held has no effect on the pool or on the map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| renValid | input | 1 | An instruction is renamed this cycle |
| renSrcA | input | 3 | First source architectural register |
| renSrcB | input | 3 | Second source architectural register |
| renDstValid | input | 1 | The instruction writes a destination |
| renDstArch | input | 3 | Destination architectural register |
| renDstTag | input | 6 | Physical tag given to the destination |
| srcAInArf | output | 1 | First source value is in the committed file |
| srcATag | output | 6 | First source physical tag |
| srcBInArf | output | 1 | Second source value is in the committed file |
| srcBTag | output | 6 | Second source physical tag |
| brAlloc | input | 1 | A branch is renamed and needs a checkpoint |
| brAllocId | output | 2 | Slot that a branch renamed this cycle receives |
| brStall | output | 1 | No checkpoint slot is free |
| resValid | input | 1 | A branch resolves this cycle |
| resMispredict | input | 1 | The resolving branch was mispredicted |
| resId | input | 2 | Checkpoint slot of the resolving branch |
| cmtValid | input | 1 | A destination commits this cycle |
| cmtArch | input | 3 | Architectural register of the commit |
| cmtTag | input | 6 | Physical tag of the commit |

## Verification
The bench uses the default build: eight architectural registers, six-bit tags and four checkpoint slots. With only four slots, the pool runs out after four nested branches, so the stall and the ignored allocation come up often. Mispredicts hit the oldest, a middle and the youngest slot, which covers releasing zero, some or all younger slots. With eight registers, commit clears often land on a tag that is still mapped in both the live map and the stored copies.

// File: rtl/rct_pkg.sv
package rct_pkg;
  parameter int ARCH_REGS  = 8;
  parameter int TAG_BITS   = 6;
  parameter int CKPT_SLOTS = 4;

  localparam int ARCH_IDX = $clog2(ARCH_REGS);
  localparam int CKPT_IDX = $clog2(CKPT_SLOTS);

  typedef struct packed {
    logic                inArf;
    logic [TAG_BITS-1:0] tag;
  } mapEntry_t;

  typedef mapEntry_t [ARCH_REGS-1:0] mapTable_t;

  typedef struct packed {
    logic                wrEn;
    logic                snapEn;
    logic [CKPT_IDX-1:0] snapId;
    logic                restoreEn;
    logic [CKPT_IDX-1:0] restoreId;
  } ratStrobe_t;
endpackage

// File: rtl/rct_ckpt_ctrl.sv
module rct_ckpt_ctrl
  import rct_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                renValid,
  input  logic                renDstValid,
  input  logic                brAlloc,
  input  logic                resValid,
  input  logic                resMispredict,
  input  logic [CKPT_IDX-1:0] resId,
  output ratStrobe_t          strobe,
  output logic [CKPT_IDX-1:0] brAllocId,
  output logic                brStall
);
  logic [CKPT_SLOTS-1:0] held;
  logic [CKPT_SLOTS-1:0] olderOf [CKPT_SLOTS];
  logic [CKPT_SLOTS-1:0] releaseMask;
  logic [CKPT_IDX-1:0]   freeId;
  logic                  freeFound;
  logic                  resHit;
  logic                  mispTake;
  logic                  grant;

  always_comb begin
    freeId    = '0;
    freeFound = 1'b0;
    for (int i = 0; i < CKPT_SLOTS; i++) begin
      if (!held[i] && !freeFound) begin
        freeId    = CKPT_IDX'(i);
        freeFound = 1'b1;
      end
    end
  end

  assign brStall  = &held;
  assign resHit   = resValid && held[resId];
  assign mispTake = resHit && resMispredict;
  assign grant    = brAlloc && !brStall && !mispTake;

  always_comb begin
    for (int i = 0; i < CKPT_SLOTS; i++) begin
      releaseMask[i] = (resHit && (resId == CKPT_IDX'(i)))
                     || (mispTake && held[i] && olderOf[i][resId]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      held <= '0;
      for (int i = 0; i < CKPT_SLOTS; i++) olderOf[i] <= '0;
    end else begin
      for (int i = 0; i < CKPT_SLOTS; i++) begin
        if (grant && (freeId == CKPT_IDX'(i))) begin
          held[i]    <= 1'b1;
          olderOf[i] <= held & ~releaseMask;
        end else begin
          held[i]    <= held[i] & ~releaseMask[i];
          olderOf[i] <= olderOf[i] & ~releaseMask;
        end
      end
    end
  end

  assign brAllocId        = freeId;
  assign strobe.wrEn      = renValid && renDstValid && !mispTake;
  assign strobe.snapEn    = grant;
  assign strobe.snapId    = freeId;
  assign strobe.restoreEn = mispTake;
  assign strobe.restoreId = resId;

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.snapEn |=> held[$past(strobe.snapId)]); // R4
  AST_STALL_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (brStall && !resValid) |=> $stable(held)); // R5
  AST_RESOLVE_FREES: assert property (@(posedge clk) disable iff (!rstN)
    resHit |=> !held[$past(resId)]); // R6
  AST_MISP_NO_NEW: assert property (@(posedge clk) disable iff (!rstN)
    mispTake |=> ((held & ~$past(held)) == '0)); // R8
  AST_MISS_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !held[resId] && !brAlloc) |=> $stable(held)); // R10
endmodule

// File: rtl/rct_map_data.sv
module rct_map_data
  import rct_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ratStrobe_t          strobe,
  input  logic [ARCH_IDX-1:0] srcA,
  input  logic [ARCH_IDX-1:0] srcB,
  input  logic [ARCH_IDX-1:0] dstArch,
  input  logic [TAG_BITS-1:0] dstTag,
  input  logic                cmtValid,
  input  logic [ARCH_IDX-1:0] cmtArch,
  input  logic [TAG_BITS-1:0] cmtTag,
  output mapEntry_t           srcAEnt,
  output mapEntry_t           srcBEnt
);
  mapTable_t liveMap;
  mapTable_t snapMap [CKPT_SLOTS];
  mapTable_t nextLive;
  mapTable_t nextSnap [CKPT_SLOTS];
  mapTable_t restoreSrc;

  function automatic mapTable_t applyClear(mapTable_t m);
    mapTable_t r;
    r = m;
    if (cmtValid && !r[cmtArch].inArf && (r[cmtArch].tag == cmtTag))
      r[cmtArch].inArf = 1'b1;
    return r;
  endfunction

  assign restoreSrc = snapMap[strobe.restoreId];

  always_comb begin
    nextLive = liveMap;
    if (strobe.wrEn) begin
      nextLive[dstArch].inArf = 1'b0;
      nextLive[dstArch].tag   = dstTag;
    end
    if (strobe.restoreEn) nextLive = restoreSrc;
    nextLive = applyClear(nextLive);
  end

  generate
    for (genvar k = 0; k < CKPT_SLOTS; k++) begin : gSnap
      always_comb begin
        if (strobe.snapEn && (strobe.snapId == CKPT_IDX'(k))) nextSnap[k] = nextLive;
        else nextSnap[k] = applyClear(snapMap[k]);
      end
      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int a = 0; a < ARCH_REGS; a++) snapMap[k][a] <= '{inArf: 1'b1, tag: '0};
        end else begin
          snapMap[k] <= nextSnap[k];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < ARCH_REGS; a++) liveMap[a] <= '{inArf: 1'b1, tag: '0};
    end else begin
      liveMap <= nextLive;
    end
  end

  assign srcAEnt = liveMap[srcA];
  assign srcBEnt = liveMap[srcB];

  AST_DST_WRITTEN: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !(cmtValid && cmtTag == dstTag))
      |=> (!liveMap[$past(dstArch)].inArf && liveMap[$past(dstArch)].tag == $past(dstTag))); // R3
  AST_RESTORE_COPY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.restoreEn && !cmtValid) |=> (liveMap == $past(restoreSrc))); // R7
  AST_CLEAR_ARF: assert property (@(posedge clk) disable iff (!rstN)
    (cmtValid && !strobe.restoreEn && !(strobe.wrEn && dstArch == cmtArch)
      && liveMap[cmtArch].tag == cmtTag) |=> liveMap[$past(cmtArch)].inArf); // R9
endmodule

// File: rtl/rename_ckpt_table.sv
module rename_ckpt_table
  import rct_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                renValid,
  input  logic [ARCH_IDX-1:0] renSrcA,
  input  logic [ARCH_IDX-1:0] renSrcB,
  input  logic                renDstValid,
  input  logic [ARCH_IDX-1:0] renDstArch,
  input  logic [TAG_BITS-1:0] renDstTag,
  output logic                srcAInArf,
  output logic [TAG_BITS-1:0] srcATag,
  output logic                srcBInArf,
  output logic [TAG_BITS-1:0] srcBTag,
  input  logic                brAlloc,
  output logic [CKPT_IDX-1:0] brAllocId,
  output logic                brStall,
  input  logic                resValid,
  input  logic                resMispredict,
  input  logic [CKPT_IDX-1:0] resId,
  input  logic                cmtValid,
  input  logic [ARCH_IDX-1:0] cmtArch,
  input  logic [TAG_BITS-1:0] cmtTag
);
  ratStrobe_t strobe;
  mapEntry_t  srcAEnt;
  mapEntry_t  srcBEnt;

  rct_ckpt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .renValid(renValid), .renDstValid(renDstValid),
    .brAlloc(brAlloc), .resValid(resValid), .resMispredict(resMispredict),
    .resId(resId), .strobe(strobe), .brAllocId(brAllocId), .brStall(brStall)
  );

  rct_map_data u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcA(renSrcA), .srcB(renSrcB),
    .dstArch(renDstArch), .dstTag(renDstTag), .cmtValid(cmtValid),
    .cmtArch(cmtArch), .cmtTag(cmtTag), .srcAEnt(srcAEnt), .srcBEnt(srcBEnt)
  );

  assign srcAInArf = srcAEnt.inArf;
  assign srcATag   = srcAEnt.tag;
  assign srcBInArf = srcBEnt.inArf;
  assign srcBTag   = srcBEnt.tag;
endmodule

// File: tb/rename_ckpt_table_bench.sv
module rename_ckpt_table_bench;
  import rct_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic                renValid, renDstValid, brAlloc, resValid, resMispredict, cmtValid;
  logic [ARCH_IDX-1:0] renSrcA, renSrcB, renDstArch, cmtArch;
  logic [TAG_BITS-1:0] renDstTag, cmtTag;
  logic [CKPT_IDX-1:0] resId;
  logic                srcAInArf, srcBInArf, brStall;
  logic [TAG_BITS-1:0] srcATag, srcBTag;
  logic [CKPT_IDX-1:0] brAllocId;

  rename_ckpt_table u_rename_ckpt_table (.*);

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  int mIn [ARCH_REGS];
  int mTag [ARCH_REGS];
  int cIn [CKPT_SLOTS][ARCH_REGS];
  int cTag [CKPT_SLOTS][ARCH_REGS];
  int cHeld [CKPT_SLOTS];
  int cSeq [CKPT_SLOTS];
  int seqCnt = 0;

  task automatic check(string req, string what, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int lowFree();
    for (int k = 0; k < CKPT_SLOTS; k++) if (cHeld[k] == 0) return k;
    return -1;
  endfunction

  task automatic modelReset();
    for (int a = 0; a < ARCH_REGS; a++) begin
      mIn[a] = 1; mTag[a] = 0;
      for (int k = 0; k < CKPT_SLOTS; k++) begin cIn[k][a] = 1; cTag[k][a] = 0; end
    end
    for (int k = 0; k < CKPT_SLOTS; k++) begin cHeld[k] = 0; cSeq[k] = 0; end
  endtask

  task automatic modelEdge();
    int nIn [ARCH_REGS];
    int nTag [ARCH_REGS];
    int fr;
    bit misp, hit;
    hit  = resValid && cHeld[resId] != 0;
    misp = hit && resMispredict;
    fr   = lowFree();
    for (int a = 0; a < ARCH_REGS; a++) begin nIn[a] = mIn[a]; nTag[a] = mTag[a]; end
    if (renValid && renDstValid && !misp) begin
      nIn[renDstArch] = 0; nTag[renDstArch] = renDstTag;
    end
    if (misp)
      for (int a = 0; a < ARCH_REGS; a++) begin nIn[a] = cIn[resId][a]; nTag[a] = cTag[resId][a]; end
    if (cmtValid) begin
      if (nIn[cmtArch] == 0 && nTag[cmtArch] == cmtTag) nIn[cmtArch] = 1;
      for (int k = 0; k < CKPT_SLOTS; k++)
        if (cIn[k][cmtArch] == 0 && cTag[k][cmtArch] == cmtTag) cIn[k][cmtArch] = 1;
    end
    if (misp) begin
      for (int k = 0; k < CKPT_SLOTS; k++)
        if (cHeld[k] != 0 && cSeq[k] > cSeq[resId]) cHeld[k] = 0;
    end
    if (hit) cHeld[resId] = 0;
    if (brAlloc && fr >= 0 && !misp) begin
      cHeld[fr] = 1; cSeq[fr] = seqCnt; seqCnt++;
      for (int a = 0; a < ARCH_REGS; a++) begin cIn[fr][a] = nIn[a]; cTag[fr][a] = nTag[a]; end
    end
    for (int a = 0; a < ARCH_REGS; a++) begin mIn[a] = nIn[a]; mTag[a] = nTag[a]; end
  endtask

  task automatic compareAll(string req);
    int fr;
    fr = lowFree();
    check(req, "srcAInArf", int'(srcAInArf), mIn[renSrcA]);
    check(req, "srcATag", int'(srcATag), mIn[renSrcA] != 0 ? int'(srcATag) : mTag[renSrcA]);
    check(req, "srcBInArf", int'(srcBInArf), mIn[renSrcB]);
    check(req, "srcBTag", int'(srcBTag), mIn[renSrcB] != 0 ? int'(srcBTag) : mTag[renSrcB]);
    check(req, "brStall", int'(brStall), fr < 0 ? 1 : 0);
    if (fr >= 0) check(req, "brAllocId", int'(brAllocId), fr);
  endtask

  task automatic idle();
    renValid = 0; renDstValid = 0; renDstArch = 0; renDstTag = 0;
    brAlloc = 0; resValid = 0; resMispredict = 0; resId = 0;
    cmtValid = 0; cmtArch = 0; cmtTag = 0;
  endtask

  task automatic cyc(string req);
    @(negedge clk);
    #1;
    compareAll(req);
    @(posedge clk);
    modelEdge();
    #1;
  endtask

  task automatic ren(int arch, int tag);
    renValid = 1; renDstValid = 1;
    renDstArch = ARCH_IDX'(arch); renDstTag = TAG_BITS'(tag);
  endtask

  task automatic look(int a, int b);
    renSrcA = ARCH_IDX'(a); renSrcB = ARCH_IDX'(b);
  endtask

  initial begin
    idle(); look(0, 0);
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    @(posedge clk); #1;
    // R1: reset state of map and pool
    for (int i = 0; i < ARCH_REGS / 2; i++) begin idle(); look(i, i + ARCH_REGS / 2); cyc("R1"); end
    // R2/R3: write r1, r2; same-cycle read sees old value
    idle(); look(1, 2); ren(1, 10); cyc("R2");
    idle(); look(1, 2); ren(2, 11); cyc("R3");
    idle(); look(1, 2); cyc("R3");
    // R4: branch with rename in the same cycle
    idle(); look(3, 1); ren(3, 12); brAlloc = 1; cyc("R4");
    idle(); look(3, 1); ren(1, 13); cyc("R4");
    idle(); brAlloc = 1; ren(4, 14); look(4, 3); cyc("R4");
    idle(); brAlloc = 1; ren(5, 15); look(5, 4); cyc("R4");
    idle(); brAlloc = 1; ren(6, 16); look(6, 5); cyc("R4");
    // R5: pool full, allocation ignored
    idle(); brAlloc = 1; ren(7, 17); look(7, 6); cyc("R5");
    idle(); brAlloc = 1; look(7, 1); cyc("R5");
    // R6: correct resolve of slot 1
    idle(); resValid = 1; resId = 1; look(1, 4); cyc("R6");
    idle(); look(1, 4); cyc("R6");
    // R10: resolve of a free slot
    idle(); resValid = 1; resMispredict = 1; resId = 1; look(1, 7); cyc("R10");
    idle(); look(1, 7); cyc("R10");
    // R9: commit clears tag 13 in live map
    idle(); cmtValid = 1; cmtArch = 1; cmtTag = 13; look(1, 3); cyc("R9");
    // R9: commit clears tag 12 in stored copies and live map
    idle(); cmtValid = 1; cmtArch = 3; cmtTag = 12; look(3, 1); cyc("R9");
    // R8: mispredict the middle slot 2, younger slot 3 goes
    idle(); resValid = 1; resMispredict = 1; resId = 2; ren(0, 20); brAlloc = 1; look(0, 5); cyc("R8");
    idle(); look(0, 5); cyc("R7");
    idle(); look(6, 7); cyc("R8");
    // R7: mispredict oldest slot 0
    idle(); resValid = 1; resMispredict = 1; resId = 0; look(3, 4); cyc("R7");
    idle(); look(3, 4); cyc("R7");
    idle(); look(1, 2); cyc("R8");
    // random phase
    for (int n = 0; n < 3000; n++) begin
      idle();
      look($urandom_range(ARCH_REGS - 1), $urandom_range(ARCH_REGS - 1));
      if ($urandom_range(1) == 1) ren($urandom_range(ARCH_REGS - 1), $urandom_range(63));
      brAlloc = ($urandom_range(2) == 0);
      resValid = ($urandom_range(3) == 0);
      resMispredict = ($urandom_range(2) == 0);
      resId = CKPT_IDX'($urandom_range(CKPT_SLOTS - 1));
      if ($urandom_range(2) == 0) begin
        int a;
        a = $urandom_range(ARCH_REGS - 1);
        cmtValid = 1; cmtArch = ARCH_IDX'(a);
        cmtTag = ($urandom_range(1) == 1) ? TAG_BITS'(mTag[a]) : TAG_BITS'($urandom_range(63));
      end
      cyc("R2");
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule